// File: doc/BRIEF.md
# Packet-Filter VM Arithmetic Unit

This unit executes the arithmetic and logic operations of a small packet-filter virtual machine. Each cycle with `in_valid` high, it takes an operation code and a destination operand. It also takes a second operand, which comes either from a register value or from a 32-bit immediate. One cycle later it presents the result together with a valid strobe. Operations run in either a full 64-bit class or a 32-bit class. In the 32-bit class only the low halves of the operands take part, and the result is zero-extended.

Two opcodes are signed divide and signed modulo. They belong to an extended instruction set and are executed only while `ext_en` is high. Otherwise they are rejected with an illegal-operation flag, as is the byte-order opcode, which this unit does not implement. Division never traps.

Top module: `pfvm_alu`

## Requirements
- R1: `res_valid` rises exactly one clock after a cycle with `in_valid` high and is low otherwise. `result` and `illegal` are updated at that same edge. Reset clears all three outputs to zero.
- R2: Opcode map: 0x0 add, 0x1 subtract, 0x2 multiply, 0x3 unsigned divide, 0x4 OR, 0x5 AND, 0x6 left shift, 0x7 logical right shift, 0x8 negate, 0x9 unsigned modulo, 0xA XOR, 0xB move, 0xC arithmetic right shift, 0xD byte order (unsupported), 0xE signed divide, 0xF signed modulo.
- R3: With `use_reg`=1 the second operand is `src`. With `use_reg`=0 it is `imm`: sign-extended to 64 bits when `alu32`=0, and taken as its 32 bits when `alu32`=1.
- R4: With `alu32`=1 both operands are reduced to their low 32 bits as unsigned values before the operation, and the 32-bit result is zero-extended to 64 bits.
- R5: Add, subtract and multiply wrap modulo 2^64 (2^32 in the 32-bit class).
- R6: Divide (0x3) and modulo (0x9) are unsigned. A zero divisor gives 0 for divide and the (class-reduced) dividend for modulo.
- R7: The shift amount is the second operand masked to 6 bits (64-bit class) or 5 bits (32-bit class). 0x6 and 0x7 fill with zeros. 0xC replicates bit 63, or bit 31 in the 32-bit class.
- R8: Negate (0x8) returns the two's complement of `dst` and ignores the second operand. Move (0xB) returns the second operand and ignores `dst`.
- R9: With `ext_en`=1, 0xE and 0xF are signed: the quotient truncates toward zero and the remainder takes the sign of the dividend. A zero divisor gives quotient 0 and remainder equal to the dividend. The most negative value divided by -1 gives the most negative value with remainder 0.
- R10: With `ext_en`=0, 0xE and 0xF set `illegal` and give `result` 0.
- R11: Opcode 0xD sets `illegal` and gives `result` 0 regardless of `ext_en`.
- R12: Any other accepted operation clears `illegal`, and `illegal` is never high without `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| alu32 | input | 1 | 1 selects the 32-bit class |
| use_reg | input | 1 | 1 selects `src`, 0 selects `imm` |
| ext_en | input | 1 | Enables signed divide and modulo |
| dst | input | 64 | Destination operand |
| src | input | 64 | Register second operand |
| imm | input | 32 | Immediate second operand |
| res_valid | output | 1 | Result valid strobe |
| result | output | 64 | Operation result |
| illegal | output | 1 | Operation was rejected |

## Verification
The bench builds the unit with its defaults: a 64-bit datapath and a 32-bit immediate. This puts the immediate at exactly the half width, so both sign extension of the immediate into the upper half and its truncation back in the 32-bit class are exercised. It also places the most-negative-by-minus-one signed corner at two distinct widths, bit 63 and bit 31. Wrap-around in multiply, and shift amounts that overrun the mask, are reachable in both classes.

// File: rtl/pfvm_alu.sv
module pfvm_alu #(
  parameter int W  = 64,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic          alu32,
  input  logic          use_reg,
  input  logic          ext_en,
  input  logic [W-1:0]  dst,
  input  logic [W-1:0]  src,
  input  logic [IW-1:0] imm,
  output logic          res_valid,
  output logic [W-1:0]  result,
  output logic          illegal
);
  localparam int HW  = W / 2;
  localparam int SW  = $clog2(W);
  localparam int SWH = $clog2(HW);

  localparam logic [3:0] OP_ADD = 4'h0, OP_SUB = 4'h1, OP_MUL = 4'h2, OP_DIV = 4'h3;
  localparam logic [3:0] OP_OR  = 4'h4, OP_AND = 4'h5, OP_LSH = 4'h6, OP_RSH = 4'h7;
  localparam logic [3:0] OP_NEG = 4'h8, OP_MOD = 4'h9, OP_XOR = 4'hA, OP_MOV = 4'hB;
  localparam logic [3:0] OP_ARS = 4'hC, OP_END = 4'hD, OP_SDV = 4'hE, OP_SMD = 4'hF;

  localparam logic [W-1:0]  MIN_W = {1'b1, {(W-1){1'b0}}};
  localparam logic [HW-1:0] MIN_H = {1'b1, {(HW-1){1'b0}}};

  logic [W-1:0] imm_x, b_raw, a, b, raw, res_n;
  logic [SW-1:0] sh;
  logic signed [W-1:0]  sa_w, sb_w, ars_w, sq_w, sr_w;
  logic signed [HW-1:0] sa_h, sb_h, ars_h, sq_h, sr_h;
  logic bad;

  assign imm_x = {{(W-IW){imm[IW-1]}}, imm};
  assign b_raw = use_reg ? src : imm_x;
  assign a     = alu32 ? {{HW{1'b0}}, dst[HW-1:0]}   : dst;
  assign b     = alu32 ? {{HW{1'b0}}, b_raw[HW-1:0]} : b_raw;
  assign sh    = alu32 ? {1'b0, b[SWH-1:0]} : b[SW-1:0];

  assign sa_w  = $signed(a);
  assign sb_w  = $signed(b);
  assign sa_h  = $signed(a[HW-1:0]);
  assign sb_h  = $signed(b[HW-1:0]);
  assign ars_w = sa_w >>> sh;
  assign ars_h = sa_h >>> sh[SWH-1:0];

  always_comb begin
    if (b == '0) begin
      sq_w = '0;
      sr_w = sa_w;
    end else if (a == MIN_W && &b) begin
      sq_w = $signed(MIN_W);
      sr_w = '0;
    end else begin
      sq_w = sa_w / sb_w;
      sr_w = sa_w % sb_w;
    end
    if (b[HW-1:0] == '0) begin
      sq_h = '0;
      sr_h = sa_h;
    end else if (a[HW-1:0] == MIN_H && &b[HW-1:0]) begin
      sq_h = $signed(MIN_H);
      sr_h = '0;
    end else begin
      sq_h = sa_h / sb_h;
      sr_h = sa_h % sb_h;
    end
  end

  assign bad = (op == OP_END) || ((op == OP_SDV || op == OP_SMD) && !ext_en);

  always_comb begin
    case (op)
      OP_ADD:  raw = a + b;
      OP_SUB:  raw = a - b;
      OP_MUL:  raw = a * b;
      OP_DIV:  raw = (b == '0) ? '0 : a / b;
      OP_OR:   raw = a | b;
      OP_AND:  raw = a & b;
      OP_LSH:  raw = a << sh;
      OP_RSH:  raw = a >> sh;
      OP_NEG:  raw = -a;
      OP_MOD:  raw = (b == '0) ? a : a % b;
      OP_XOR:  raw = a ^ b;
      OP_MOV:  raw = b;
      OP_ARS:  raw = alu32 ? {{HW{1'b0}}, ars_h} : ars_w;
      OP_SDV:  raw = alu32 ? {{HW{1'b0}}, sq_h} : sq_w;
      OP_SMD:  raw = alu32 ? {{HW{1'b0}}, sr_h} : sr_w;
      default: raw = '0;
    endcase
  end

  assign res_n = bad ? '0 : alu32 ? {{HW{1'b0}}, raw[HW-1:0]} : raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        result  <= res_n;
        illegal <= bad;
      end else begin
        illegal <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pfvm_alu_chk.sv
module pfvm_alu_chk #(
  parameter int W  = 64,
  parameter int IW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [3:0]    op,
  input logic          alu32,
  input logic          use_reg,
  input logic          ext_en,
  input logic [W-1:0]  dst,
  input logic [W-1:0]  src,
  input logic [IW-1:0] imm,
  input logic          res_valid,
  input logic [W-1:0]  result,
  input logic          illegal
);
  localparam int HW = W / 2;

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);
  a_r4_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && alu32) |=> (result[W-1:HW] == '0));
  a_r8_move_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'hB && use_reg && !alu32) |=> (result == $past(src)));
  a_r10_gated_signed: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[3:1] == 3'b111 && !ext_en) |=> (illegal && result == '0));
  a_r11_end_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'hD) |=> (illegal && result == '0));
  a_r12_legal_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != 4'hD && !(op[3:1] == 3'b111 && !ext_en)) |=> !illegal);
  a_r12_flag_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> res_valid);
endmodule

bind pfvm_alu pfvm_alu_chk #(.W(W), .IW(IW)) u_chk (.*);

// File: tb/pfvm_alu_test.sv
`timescale 1ns/1ps
module pfvm_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic        alu32 = 1'b0, use_reg = 1'b0, ext_en = 1'b0;
  logic [63:0] dst = '0, src = '0;
  logic [31:0] imm = '0;
  logic        res_valid, illegal;
  logic [63:0] result;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  pfvm_alu uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .alu32(alu32),
    .use_reg(use_reg), .ext_en(ext_en), .dst(dst), .src(src), .imm(imm),
    .res_valid(res_valid), .result(result), .illegal(illegal));

  // {op, alu32, use_reg, ext_en, dst, src, imm, expected, expected_illegal, req}
  localparam int NV = 38;
  localparam logic [239:0] VEC [NV] = '{
    {4'h0,1'b0,1'b1,1'b0,64'h5,64'h7,32'h0,64'hC,1'b0,8'd5},                                  // R5
    {4'h0,1'b0,1'b0,1'b0,64'h10,64'h0,32'hFFFFFFFF,64'hF,1'b0,8'd3},                            // R3
    {4'h0,1'b1,1'b0,1'b0,64'hAAAA000000000010,64'h0,32'hFFFFFFFF,64'hF,1'b0,8'd4},              // R4
    {4'h1,1'b0,1'b1,1'b0,64'h0,64'h1,32'h0,64'hFFFFFFFFFFFFFFFF,1'b0,8'd5},                     // R5
    {4'h1,1'b1,1'b1,1'b0,64'h0,64'h1,32'h0,64'h00000000FFFFFFFF,1'b0,8'd4},                     // R4
    {4'h2,1'b0,1'b1,1'b0,64'h100000000,64'h100000000,32'h0,64'h0,1'b0,8'd5},                    // R5
    {4'h2,1'b1,1'b1,1'b0,64'h10001,64'h10001,32'h0,64'h20001,1'b0,8'd4},                        // R4
    {4'h3,1'b0,1'b1,1'b0,64'hFFFFFFFFFFFFFFFF,64'h2,32'h0,64'h7FFFFFFFFFFFFFFF,1'b0,8'd6},      // R6
    {4'h3,1'b0,1'b1,1'b0,64'h123,64'h0,32'h0,64'h0,1'b0,8'd6},                                  // R6
    {4'h9,1'b0,1'b1,1'b0,64'd17,64'd5,32'h0,64'd2,1'b0,8'd6},                                   // R6
    {4'h9,1'b0,1'b1,1'b0,64'h1234,64'h0,32'h0,64'h1234,1'b0,8'd6},                              // R6
    {4'h9,1'b1,1'b1,1'b0,64'hFFFFFFFF00001234,64'h0,32'h0,64'h1234,1'b0,8'd4},                  // R4
    {4'h4,1'b0,1'b0,1'b0,64'hF0,64'h0,32'h0F,64'hFF,1'b0,8'd2},                                 // R2
    {4'h5,1'b0,1'b0,1'b0,64'hFFFFFFFFFFFFFFFF,64'h0,32'h80000000,64'hFFFFFFFF80000000,1'b0,8'd3}, // R3
    {4'h5,1'b1,1'b0,1'b0,64'hFFFFFFFFFFFFFFFF,64'h0,32'h80000000,64'h80000000,1'b0,8'd3},        // R3
    {4'hA,1'b0,1'b1,1'b0,64'hFF,64'h0F,32'h0,64'hF0,1'b0,8'd2},                                 // R2
    {4'h6,1'b0,1'b1,1'b0,64'h1,64'h41,32'h0,64'h2,1'b0,8'd7},                                   // R7
    {4'h6,1'b1,1'b1,1'b0,64'h80000001,64'h21,32'h0,64'h2,1'b0,8'd7},                            // R7
    {4'h7,1'b0,1'b1,1'b0,64'h8000000000000000,64'd63,32'h0,64'h1,1'b0,8'd7},                    // R7
    {4'h7,1'b1,1'b1,1'b0,64'hFFFFFFFF80000000,64'd31,32'h0,64'h1,1'b0,8'd7},                    // R7
    {4'hC,1'b0,1'b1,1'b0,64'h8000000000000000,64'd4,32'h0,64'hF800000000000000,1'b0,8'd7},      // R7
    {4'hC,1'b1,1'b1,1'b0,64'h80000000,64'd4,32'h0,64'hF8000000,1'b0,8'd7},                      // R7
    {4'h8,1'b0,1'b1,1'b0,64'h1,64'h99,32'h0,64'hFFFFFFFFFFFFFFFF,1'b0,8'd8},                    // R8
    {4'h8,1'b1,1'b1,1'b0,64'h1,64'h99,32'h0,64'hFFFFFFFF,1'b0,8'd8},                            // R8
    {4'hB,1'b0,1'b0,1'b0,64'h55,64'h0,32'hFFFFFFFE,64'hFFFFFFFFFFFFFFFE,1'b0,8'd8},             // R8
    {4'hB,1'b1,1'b1,1'b0,64'h55,64'h123456789,32'h0,64'h23456789,1'b0,8'd8},                    // R8
    {4'hE,1'b0,1'b1,1'b1,64'hFFFFFFFFFFFFFFF9,64'h2,32'h0,64'hFFFFFFFFFFFFFFFD,1'b0,8'd9},      // R9
    {4'hF,1'b0,1'b1,1'b1,64'hFFFFFFFFFFFFFFF9,64'h2,32'h0,64'hFFFFFFFFFFFFFFFF,1'b0,8'd9},      // R9
    {4'hE,1'b0,1'b1,1'b1,64'h8000000000000000,64'hFFFFFFFFFFFFFFFF,32'h0,64'h8000000000000000,1'b0,8'd9}, // R9
    {4'hF,1'b0,1'b1,1'b1,64'h8000000000000000,64'hFFFFFFFFFFFFFFFF,32'h0,64'h0,1'b0,8'd9},      // R9
    {4'hE,1'b1,1'b1,1'b1,64'hFFFFFFF9,64'h2,32'h0,64'hFFFFFFFD,1'b0,8'd9},                      // R9
    {4'hE,1'b1,1'b0,1'b1,64'h80000000,64'h0,32'hFFFFFFFF,64'h80000000,1'b0,8'd9},               // R9
    {4'hF,1'b1,1'b0,1'b1,64'h80000000,64'h0,32'hFFFFFFFF,64'h0,1'b0,8'd9},                      // R9
    {4'hE,1'b0,1'b1,1'b1,64'h77,64'h0,32'h0,64'h0,1'b0,8'd9},                                   // R9
    {4'hF,1'b0,1'b1,1'b1,64'hFFFFFFFFFFFFFFF9,64'h0,32'h0,64'hFFFFFFFFFFFFFFF9,1'b0,8'd9},      // R9
    {4'hE,1'b0,1'b1,1'b0,64'h8,64'h2,32'h0,64'h0,1'b1,8'd10},                                   // R10
    {4'hF,1'b1,1'b1,1'b0,64'h8,64'h3,32'h0,64'h0,1'b1,8'd10},                                   // R10
    {4'hD,1'b0,1'b1,1'b1,64'h8,64'h3,32'h0,64'h0,1'b1,8'd11}                                    // R11
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset res_valid", {63'b0, res_valid}, 64'h0);
    check("R1 reset result", result, 64'h0);
    check("R1 reset illegal", {63'b0, illegal}, 64'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [239:0] v;
      string tag;
      v = VEC[i];
      op = v[239:236]; alu32 = v[235]; use_reg = v[234]; ext_en = v[233];
      dst = v[232:169]; src = v[168:105]; imm = v[104:73];
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tag = $sformatf("R%0d row %0d", v[7:0], i);
      check({tag, " result/illegal/valid"}, {result[62:0] ^ {62'b0, illegal}, res_valid},
            {v[71:9] ^ {62'b0, v[8]}, 1'b1});
      if (!v[8]) check({tag, " R12 illegal low"}, {63'b0, illegal}, 64'h0);
    end

    // R1: idle cycle drops the strobe; R12: flag cleared on idle
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 idle res_valid", {63'b0, res_valid}, 64'h0);
    check("R12 idle illegal", {63'b0, illegal}, 64'h0);

    // R1: back-to-back operations each appear one cycle later
    op = 4'h0; alu32 = 1'b0; use_reg = 1'b1; ext_en = 1'b0;
    dst = 64'd100; src = 64'd1; in_valid = 1'b1;
    @(negedge clk);
    check("R1 b2b first", result, 64'd101);
    dst = 64'd200; src = 64'd2;
    @(negedge clk);
    check("R1 b2b second", result, 64'd202);
    in_valid = 1'b0;

    // R11: END stays illegal with extension off too
    op = 4'hD; ext_en = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R11 end ext off", {result[62:0], illegal}, {63'b0, 1'b1});

    // R1: reset in flight clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset", {result[61:0], res_valid, illegal}, 64'h0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule